// File: doc/BRIEF.md
# Opcode-Fetch Trap Memory Overlay

This block is the paging controller for an 8-bit CPU with a 16-bit address bus. It watches opcode fetches. When the CPU fetches an instruction from one of six fixed trap addresses, the block swaps the lowest 16 KB of the address space away from the main ROM. Firmware in an overlay ROM and a banked 128 KB overlay RAM take its place. The swap is held back until the refresh phase of that same fetch. The trapped opcode byte therefore still comes from the main ROM, and every later access in the region comes from the overlay.

While the overlay is mapped, the lower 8 KB of the region selects the overlay ROM. The upper 8 KB selects one 8 KB page of overlay RAM, and the controller drives the upper address bits of that page. A fetch from the last eight bytes of the overlay ROM window (0x1FF8 to 0x1FFF) unmaps the overlay, with the same refresh-phase delay. A write-only control register, loaded through an I/O write strobe, holds the RAM page number. It also holds a force bit that keeps the overlay mapped with no trap and blocks the exit range from unmapping it.

The bus is modelled one phase per clock. A fetch phase has `fetch`, `mreq` and `rd` high. A refresh phase has `rfsh` and `mreq` high. Plain data reads and writes have `mreq` with `rd`, or `mreq` alone.

Top module: `trap_overlay_pager`

## Requirements
- R1: After reset, the overlay is unmapped, the force bit is clear and `ram_bank` is 0. A read at any address below 0x4000 asserts only `main_rom_cs`.
- R2: A fetch phase at 0x0000, 0x0008, 0x0038, 0x0066, 0x04C2 or 0x0562 is itself served by `main_rom_cs`. After the following refresh phase, reads below 0x2000 assert `ovl_rom_cs`.
- R3: While the overlay is mapped, addresses 0x0000 to 0x1FFF assert `ovl_rom_cs` and 0x2000 to 0x3FFF assert `ovl_ram_cs`. While it is unmapped, both ranges assert `main_rom_cs`. Addresses 0x4000 and above assert no select. At most one select is high at any time.
- R4: An I/O write loads `io_data[3:0]` into the RAM page number, and `ram_bank` shows that value from the next clock on.
- R5: A data read, a data write or a refresh-only phase at a trap address does not map the overlay.
- R6: A fetch at 0x0066 while the overlay is already mapped is served by `ovl_rom_cs`.
- R7: While the overlay is mapped and the force bit is clear, a fetch at 0x1FF8 to 0x1FFF is itself served by `ovl_rom_cs`. After the following refresh phase, low reads select the main ROM.
- R8: An I/O write with `io_data[7]` set maps the overlay from the next clock on, without a trap. While the bit is set, an exit-range fetch does not unmap the overlay. Writing the bit clear unmaps the overlay if no trap has mapped it.
- R9: No select is asserted during a refresh phase or when `mreq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus phase per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address bus |
| fetch | input | 1 | Opcode-fetch phase strobe |
| mreq | input | 1 | Memory request strobe |
| rd | input | 1 | Read strobe |
| rfsh | input | 1 | Refresh phase strobe |
| io_wr | input | 1 | Write strobe for the control register |
| io_data | input | 8 | Control data: bit 7 is the force bit, bits 3:0 are the RAM page |
| main_rom_cs | output | 1 | Main ROM select |
| ovl_rom_cs | output | 1 | Overlay ROM select |
| ovl_ram_cs | output | 1 | Overlay RAM select |
| ram_bank | output | 4 | Upper overlay RAM address bits (A16 to A13) |

## Verification
Fetches at each trap address are compared with data reads, data writes and refresh-only phases at the same addresses. This shows that only an opcode fetch arms the overlay (R5). The select seen during the trapped fetch is compared with the select on the next read, which shows the one-phase delay in both the mapping and unmapping directions. A repeat fetch at 0x0066 with the overlay mapped shows that a nested entry reads from the overlay (R6). Random sequences of fetch/refresh pairs, data accesses and control writes, some with the force bit, are checked against a reference model in the bench. These cover the interplay of pending traps, exits and forced mapping.

// File: rtl/ovl_pkg.sv
// Package: constants and helper types shared by the overlay pager.
// Assumes a 16-bit address bus and a fixed list of six trap addresses.
package ovl_pkg;
    localparam int N_TRAPS = 6;
    localparam logic [15:0] TRAP_ADDRS [N_TRAPS] = '{
        16'h0000, 16'h0008, 16'h0038, 16'h0066, 16'h04C2, 16'h0562
    };

    // Chip select bundle driven toward the memories.
    typedef struct packed {
        logic main_rom;
        logic ovl_rom;
        logic ovl_ram;
    } cs_t;

    // True when the address is one of the trap addresses.
    function automatic logic is_trap_addr(input logic [15:0] a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_TRAPS; i++) begin
            if (a == TRAP_ADDRS[i]) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/ovl_trap_decode.sv
// Module: address decoder for trap entries and the overlay exit range.
// Purely combinational. It assumes the caller qualifies the hits with
// an opcode-fetch phase.
module ovl_trap_decode
    import ovl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int EXIT_LSB  = 3,
    parameter logic [ADDR_W-1:0] EXIT_BASE = 16'h1FF8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              trap_hit,
    output logic              exit_hit
);
    logic [N_TRAPS-1:0] match_vec;

    // One comparator per trap address.
    for (genvar g = 0; g < N_TRAPS; g++) begin : g_trap_cmp
        assign match_vec[g] = (addr == TRAP_ADDRS[g][ADDR_W-1:0]);
    end

    // Combine the comparators and decode the exit window.
    always_comb begin
        trap_hit = |match_vec;
        exit_hit = (addr[ADDR_W-1:EXIT_LSB] == EXIT_BASE[ADDR_W-1:EXIT_LSB]);
    end
endmodule

// File: rtl/ovl_ctrl_reg.sv
// Module: write-only control register holding the RAM page and the force bit.
// Assumes the I/O port decode is done outside and arrives as io_wr.
module ovl_ctrl_reg #(
    parameter int DATA_W    = 8,
    parameter int BANK_W    = 4,
    parameter int FORCE_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_data,
    output logic [BANK_W-1:0] bank_q,
    output logic              force_q
);
    // Load the page number and the force bit on an I/O write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= '0;
            force_q <= 1'b0;
        end else if (io_wr) begin
            bank_q  <= io_data[BANK_W-1:0];
            force_q <= io_data[FORCE_BIT];
        end
    end
endmodule

// File: rtl/ovl_map_state.sv
// Module: overlay mapping state with refresh-phase deferral.
// A fetch records a pending map or unmap request. The next refresh phase
// applies it. A later fetch before any refresh replaces the request.
module ovl_map_state (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_cyc,
    input  logic rfsh_cyc,
    input  logic trap_hit,
    input  logic exit_hit,
    input  logic force_on,
    output logic ovl_on
);
    logic active_q;
    logic pend_map_q;
    logic pend_unmap_q;

    // Capture requests on fetch phases and clear them on refresh phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_map_q   <= 1'b0;
            pend_unmap_q <= 1'b0;
        end else if (fetch_cyc) begin
            pend_map_q   <= trap_hit;
            pend_unmap_q <= exit_hit && ovl_on;
        end else if (rfsh_cyc) begin
            pend_map_q   <= 1'b0;
            pend_unmap_q <= 1'b0;
        end
    end

    // Apply a pending request in the refresh phase of its fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (rfsh_cyc) begin
            if (pend_map_q) begin
                active_q <= 1'b1;
            end else if (pend_unmap_q && !force_on) begin
                active_q <= 1'b0;
            end
        end
    end

    // The force bit maps the overlay regardless of trap state.
    always_comb ovl_on = active_q || force_on;
endmodule

// File: rtl/ovl_select.sv
// Module: chip select decode for the low 16 KB region.
// Assumes the low region is the bottom quarter of the address space,
// split into a ROM half and a RAM half.
module ovl_select
    import ovl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_cyc,
    input  logic              ovl_on,
    output cs_t               cs
);
    localparam int SPLIT_BIT = ADDR_W - 3;

    logic low_region;

    // Route the low region to the main ROM or to the overlay.
    always_comb begin
        low_region  = (addr[ADDR_W-1:ADDR_W-2] == 2'b00) && mem_cyc;
        cs.main_rom = low_region && !ovl_on;
        cs.ovl_rom  = low_region && ovl_on && !addr[SPLIT_BIT];
        cs.ovl_ram  = low_region && ovl_on &&  addr[SPLIT_BIT];
    end
endmodule

// File: rtl/trap_overlay_pager.sv
// Module: top level of the trap-driven overlay paging controller.
// It ties the decoder, control register, mapping state and select decode
// together. Assumes one bus phase per clock with active-high strobes.
module trap_overlay_pager
    import ovl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fetch,
    input  logic              mreq,
    input  logic              rd,
    input  logic              rfsh,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_data,
    output logic              main_rom_cs,
    output logic              ovl_rom_cs,
    output logic              ovl_ram_cs,
    output logic [BANK_W-1:0] ram_bank
);
    logic fetch_cyc;
    logic rfsh_cyc;
    logic mem_cyc;
    logic trap_hit;
    logic exit_hit;
    logic force_on;
    logic ovl_on;
    cs_t  cs;

    // Classify the current bus phase.
    always_comb begin
        fetch_cyc = fetch && mreq && rd && !rfsh;
        rfsh_cyc  = rfsh && mreq;
        mem_cyc   = mreq && !rfsh;
    end

    ovl_trap_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr     (addr),
        .trap_hit (trap_hit),
        .exit_hit (exit_hit)
    );

    ovl_ctrl_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_data (io_data),
        .bank_q  (ram_bank),
        .force_q (force_on)
    );

    ovl_map_state i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_cyc (fetch_cyc),
        .rfsh_cyc  (rfsh_cyc),
        .trap_hit  (trap_hit),
        .exit_hit  (exit_hit),
        .force_on  (force_on),
        .ovl_on    (ovl_on)
    );

    ovl_select #(.ADDR_W(ADDR_W)) i_select (
        .addr    (addr),
        .mem_cyc (mem_cyc),
        .ovl_on  (ovl_on),
        .cs      (cs)
    );

    // Drive the select outputs from the decoded bundle.
    always_comb begin
        main_rom_cs = cs.main_rom;
        ovl_rom_cs  = cs.ovl_rom;
        ovl_ram_cs  = cs.ovl_ram;
    end
endmodule

// File: rtl/ovl_pager_chk.sv
// Checker: temporal properties of the overlay pager, bound to the top.
module ovl_pager_chk
    import ovl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        fetch,
    input logic        mreq,
    input logic        rd,
    input logic        rfsh,
    input logic        io_wr,
    input logic [7:0]  io_data,
    input logic        main_rom_cs,
    input logic        ovl_rom_cs,
    input logic        ovl_ram_cs,
    input logic [3:0]  ram_bank,
    input logic        force_on
);
    // R9
    no_cs_in_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh || !mreq) |-> !(main_rom_cs || ovl_rom_cs || ovl_ram_cs));

    // R3
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_rom_cs, ovl_rom_cs, ovl_ram_cs}));

    // R3
    high_area_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] != 2'b00) |-> !(main_rom_cs || ovl_rom_cs || ovl_ram_cs));

    // R4
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> (ram_bank == $past(io_data[3:0])));

    // R2
    trap_maps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fetch && mreq && rd && !rfsh && is_trap_addr(addr), 2) &&
         $past(rfsh && mreq) && mreq && !rfsh && addr[15:13] == 3'b000)
        |-> ovl_rom_cs);

    // R7
    exit_unmaps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fetch && mreq && rd && !rfsh && addr[15:3] == 13'h03FF && ovl_rom_cs, 2) &&
         $past(rfsh && mreq && !force_on) && $past(!io_wr) && !force_on &&
         mreq && !rfsh && addr[15:14] == 2'b00)
        |-> main_rom_cs);
endmodule

bind trap_overlay_pager ovl_pager_chk i_pager_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .fetch       (fetch),
    .mreq        (mreq),
    .rd          (rd),
    .rfsh        (rfsh),
    .io_wr       (io_wr),
    .io_data     (io_data),
    .main_rom_cs (main_rom_cs),
    .ovl_rom_cs  (ovl_rom_cs),
    .ovl_ram_cs  (ovl_ram_cs),
    .ram_bank    (ram_bank),
    .force_on    (force_on)
);

// File: tb/test_trap_overlay_pager.sv
module test_trap_overlay_pager;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        fetch = 1'b0, mreq = 1'b0, rd = 1'b0, rfsh = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_data = '0;
    logic        main_rom_cs, ovl_rom_cs, ovl_ram_cs;
    logic [3:0]  ram_bank;

    int checks = 0;
    int errors = 0;
    logic [2:0] got_cs;

    // Reference model state.
    logic m_active = 1'b0, m_force = 1'b0, m_pmap = 1'b0, m_punmap = 1'b0;
    logic [3:0] m_bank = '0;

    localparam logic [15:0] TRAPS [6] = '{16'h0000, 16'h0008, 16'h0038,
                                          16'h0066, 16'h04C2, 16'h0562};

    trap_overlay_pager i_trap_overlay_pager (
        .clk(clk), .rst_n(rst_n), .addr(addr), .fetch(fetch), .mreq(mreq),
        .rd(rd), .rfsh(rfsh), .io_wr(io_wr), .io_data(io_data),
        .main_rom_cs(main_rom_cs), .ovl_rom_cs(ovl_rom_cs),
        .ovl_ram_cs(ovl_ram_cs), .ram_bank(ram_bank)
    );

    always #10 clk = ~clk;

    function automatic logic trap_at(input logic [15:0] a);
        logic h = 1'b0;
        for (int i = 0; i < 6; i++) if (a == TRAPS[i]) h = 1'b1;
        return h;
    endfunction

    // Expected selects {main, ovl_rom, ovl_ram}.
    function automatic logic [2:0] exp_cs(input logic [15:0] a, input logic m,
                                          input logic rf, input logic on);
        if (!m || rf || a[15:14] != 2'b00) return 3'b000;
        if (!on) return 3'b100;
        return a[13] ? 3'b001 : 3'b010;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One bus phase: drive, sample before the edge, compare, update model.
    task automatic phase(input string tag, input logic f, input logic m,
                         input logic r, input logic rf, input logic [15:0] a);
        logic on;
        @(negedge clk);
        fetch = f; mreq = m; rd = r; rfsh = rf; addr = a; io_wr = 1'b0;
        #5;
        got_cs = {main_rom_cs, ovl_rom_cs, ovl_ram_cs};
        on = m_active || m_force;
        check(tag, {5'd0, got_cs}, {5'd0, exp_cs(a, m, rf, on)});
        if (f && m && r && !rf) begin
            m_pmap   = trap_at(a);
            m_punmap = (a[15:3] == 13'h03FF) && on;
        end else if (rf && m) begin
            if (m_pmap) m_active = 1'b1;
            else if (m_punmap && !m_force) m_active = 1'b0;
            m_pmap = 1'b0; m_punmap = 1'b0;
        end
    endtask

    task automatic io_write(input logic [7:0] d);
        @(negedge clk);
        fetch = 0; mreq = 0; rd = 0; rfsh = 0; io_wr = 1'b1; io_data = d;
        m_bank = d[3:0]; m_force = d[7];
    endtask

    task automatic fetch_pair(input string tag, input logic [15:0] a);
        phase(tag, 1, 1, 1, 0, a);
        phase(tag, 0, 1, 0, 1, a);
    endtask

    initial begin : watchdog
        #3000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        phase("R1", 0, 1, 1, 0, 16'h0100);
        phase("R1", 0, 1, 1, 0, 16'h2100);
        check("R1", {4'd0, ram_bank}, 8'd0);
        // R5: non-fetch accesses at traps do not map
        for (int i = 0; i < 6; i++) begin
            phase("R5", 0, 1, 1, 0, TRAPS[i]);
            phase("R5", 0, 1, 0, 0, TRAPS[i]);
            phase("R5", 0, 1, 0, 1, TRAPS[i]);
        end
        phase("R5", 0, 1, 1, 0, 16'h0010);
        // R2, R7: each trap maps, exit unmaps
        for (int i = 0; i < 6; i++) begin
            fetch_pair("R2", TRAPS[i]);
            phase("R2", 0, 1, 1, 0, 16'h0200);
            phase("R3", 0, 1, 1, 0, 16'h3000);
            phase("R3", 0, 1, 1, 0, 16'h8000);
            // R6: nested entry at 0x0066 from overlay
            fetch_pair("R6", 16'h0066);
            fetch_pair("R7", 16'h1FF8 + 16'(i));
            phase("R7", 0, 1, 1, 0, 16'h0000);
        end
        // R9: idle bus
        phase("R9", 0, 0, 1, 0, 16'h0000);
        // R4, R8: forced mapping and bank load
        io_write(8'h8A);
        phase("R8", 0, 1, 1, 0, 16'h0400);
        check("R4", {4'd0, ram_bank}, 8'h0A);
        fetch_pair("R8", 16'h1FFC);
        phase("R8", 0, 1, 1, 0, 16'h0400);
        io_write(8'h05);
        phase("R8", 0, 1, 1, 0, 16'h0400);
        check("R4", {4'd0, ram_bank}, 8'h05);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [15:0] a;
            op = $urandom % 10;
            case ($urandom % 4)
                0: a = TRAPS[$urandom % 6];
                1: a = 16'h1FF8 + 16'($urandom % 8);
                2: a = 16'($urandom % 16'h4000);
                default: a = 16'($urandom);
            endcase
            case (op)
                0, 1, 2, 3: fetch_pair("R2", a);
                4: phase("R5", 0, 1, 1, 0, a);
                5: phase("R5", 0, 1, 0, 0, a);
                6: phase("R9", 0, 1, 0, 1, a);
                7: phase("R9", 1, 0, 1, 0, a);
                8: begin
                    io_write({($urandom % 4 == 0), 3'b000, 4'($urandom)});
                    phase("R4", 0, 1, 1, 0, 16'h2000);
                    check("R4", {4'd0, ram_bank}, {4'd0, m_bank});
                end
                default: phase("R3", 0, 1, 1, 0, a);
            endcase
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule